// File: doc/BRIEF.md
# Half-Row Activation Gate

This block decides, every controller clock cycle, whether a requested half-row activation to one DRAM bank may be issued. The bank's rows are split into an even half and an odd half, each with its own latch, so a request names a row address, a sub-array and which half it wants. The grant is combinational from the block's state and the current request. An activation counts as issued in any cycle where the request and the grant are both high. A rejected request raises no error: the scheduler keeps requesting and the grant stays low until every rule is met.

Three rules are enforced at once. The first is an open-state policy chosen by a mode input, one of single-half, demand or dual-half. The second is a minimum spacing between activations that go to different rows. The third is a rolling limit on how many activations may fall inside one window. A precharge clears all open half-row state in one cycle. The timing history is kept across precharges, because those rules constrain the issue times of activations and not which rows are open.

Top module: `hrow_act_gate`

## Requirements
- R1: After reset no half-row is open and no activation history exists, so the first request in any mode is granted. With the request input low, the grant is always low.
- R2: A request in the same cycle as a precharge is not granted. A precharge closes both halves, so the cycle after it sees an empty bank.
- R3: With the mode input at 0 (single-half, and also for the unused code 3), a request is granted only while neither half is open.
- R4: With the mode input at 1 (demand), a request is granted when no half is open. It is also granted when only the other half is open and that half holds the same row address and sub-array as the request.
- R5: With the mode input at 2 (dual-half), a request for a half is granted while the other half is empty. It is also granted while the other half is open in a different sub-array with any row, or in the same sub-array with the same row.
- R6: In every mode, a request for a half that is already open is rejected. While both halves are open, every request is rejected until a precharge.
- R7: A request whose row address or sub-array differs from the last issued activation is granted only if at least TRRD cycles have passed since that issue. A request for the same row and sub-array is exempt.
- R8: A request is granted only if fewer than NACT activations have been issued, or the NACT-th most recent one was issued at least TFAW cycles ago. No TFAW consecutive cycles therefore hold more than NACT issues.
- R9: An activation issues exactly when request and grant are both high. A precharge does not clear the spacing or window history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Policy: 0 single-half, 1 demand, 2 dual-half, 3 as 0 |
| act_req_i | input | 1 | Activation requested this cycle |
| act_row_i | input | ROW_W | Row address of the request |
| act_sub_i | input | SUB_W | Sub-array of the request |
| act_half_i | input | 1 | Half select: 0 even, 1 odd |
| pre_i | input | 1 | Precharge issued to the bank this cycle |
| act_grant_o | output | 1 | Request may issue this cycle |

## Verification
A stale or lost half latch would show as a wrong grant on the very next request that touches the other half. This is visible after one issue, one idle gap and one request. A spacing counter that is off by one shows as a grant one cycle early or late at the boundary gap, which the sweep over gaps 0 to TRRD+1 hits directly. A window queue that loses or duplicates an entry shows only once NACT issues have gathered. The back-to-back issue and precharge bursts reach that point within about 2·NACT cycles. A long pseudo-random run, compared cycle by cycle against an arithmetic model, covers the mixed cases.

// File: rtl/hrow_pkg.sv
// Shared types for the half-row activation gate.
package hrow_pkg;

    // Activation policy selected by the mode input.
    typedef enum logic [1:0] {
        POL_SINGLE = 2'd0,
        POL_DEMAND = 2'd1,
        POL_DUAL   = 2'd2,
        POL_RSVD   = 2'd3
    } act_pol_e;

endpackage

// File: rtl/hrow_rrd_timer.sv
// Activation spacing timer.
// Remembers the row and sub-array of the last issued activation and counts
// the cycles since then, saturating at TRRD. ok_o is high when the current
// request targets the same row and sub-array, or when TRRD cycles have passed.
// Assumes TRRD >= 1.
module hrow_rrd_timer #(
    parameter int ROW_W = 4,
    parameter int SUB_W = 2,
    parameter int TRRD  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [SUB_W-1:0] sub_i,
    output logic             ok_o
);
    localparam int CW = $clog2(TRRD + 1);

    logic [CW-1:0]    since_q;
    logic             have_q;
    logic [ROW_W-1:0] row_q;
    logic [SUB_W-1:0] sub_q;

    // Record the last issued target and count cycles since it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            have_q  <= 1'b0;
            row_q   <= '0;
            sub_q   <= '0;
        end else if (issue_i) begin
            since_q <= CW'(1);
            have_q  <= 1'b1;
            row_q   <= row_i;
            sub_q   <= sub_i;
        end else if (since_q < CW'(TRRD)) begin
            since_q <= since_q + CW'(1);
        end
    end

    // Spacing is met, not needed yet, or waived for the same row.
    always_comb begin
        ok_o = !have_q || (since_q >= CW'(TRRD)) ||
               ((row_i == row_q) && (sub_i == sub_q));
    end
endmodule

// File: rtl/hrow_faw_window.sv
// Rolling activation window.
// Keeps the ages of the last NACT issued activations in a shift queue. The
// newest entry is in slot 0 and the NACT-th most recent is in the last slot.
// Ages saturate at TFAW. ok_o is high when the last slot is empty or old enough.
// Assumes TFAW >= 1 and NACT >= 2.
module hrow_faw_window #(
    parameter int NACT = 8,
    parameter int TFAW = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    output logic ok_o
);
    localparam int AW = $clog2(TFAW + 1);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
        return (a >= AW'(TFAW)) ? a : a + AW'(1);
    endfunction

    for (genvar i = 0; i < NACT; i++) begin : g_slot
        logic          vld_q;
        logic [AW-1:0] age_q;
        if (i == 0) begin : g_head
            // Load a fresh entry on issue, otherwise age the head.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    age_q <= '0;
                end else if (issue_i) begin
                    vld_q <= 1'b1;
                    age_q <= AW'(1);
                end else begin
                    age_q <= bump(age_q);
                end
            end
        end else begin : g_tail
            // Shift the older entry in on issue, otherwise age in place.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    age_q <= '0;
                end else if (issue_i) begin
                    vld_q <= g_slot[i-1].vld_q;
                    age_q <= bump(g_slot[i-1].age_q);
                end else begin
                    age_q <= bump(age_q);
                end
            end
        end
    end

    // Admit when the NACT-th most recent issue is missing or aged out.
    always_comb begin
        ok_o = !g_slot[NACT-1].vld_q || (g_slot[NACT-1].age_q >= AW'(TFAW));
    end
endmodule

// File: rtl/hrow_open_track.sv
// Half-row open-state tracker and policy check.
// Keeps one latch per half (even = 0, odd = 1) with its row and sub-array.
// A precharge clears both latches. policy_ok_o applies the selected policy
// to the current request. Assumes issue_i never coincides with pre_i.
module hrow_open_track
    import hrow_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int SUB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  act_pol_e         mode_i,
    input  logic             issue_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [SUB_W-1:0] sub_i,
    input  logic             half_i,
    output logic             policy_ok_o
);
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic             vld_q;
        logic [ROW_W-1:0] row_q;
        logic [SUB_W-1:0] sub_q;
        // Open this half on issue, close it on precharge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                row_q <= '0;
                sub_q <= '0;
            end else if (pre_i) begin
                vld_q <= 1'b0;
            end else if (issue_i && (half_i == 1'(h))) begin
                vld_q <= 1'b1;
                row_q <= row_i;
                sub_q <= sub_i;
            end
        end
    end

    logic             own_vld, oth_vld;
    logic [ROW_W-1:0] oth_row;
    logic [SUB_W-1:0] oth_sub;

    // Select the requested half and its partner.
    always_comb begin
        own_vld = half_i ? g_half[1].vld_q : g_half[0].vld_q;
        oth_vld = half_i ? g_half[0].vld_q : g_half[1].vld_q;
        oth_row = half_i ? g_half[0].row_q : g_half[1].row_q;
        oth_sub = half_i ? g_half[0].sub_q : g_half[1].sub_q;
    end

    // Apply the selected open-state policy.
    always_comb begin
        unique case (mode_i)
            POL_DEMAND: policy_ok_o = !own_vld &&
                (!oth_vld || ((oth_row == row_i) && (oth_sub == sub_i)));
            POL_DUAL:   policy_ok_o = !own_vld &&
                (!oth_vld || (oth_sub != sub_i) || (oth_row == row_i));
            default:    policy_ok_o = !g_half[0].vld_q && !g_half[1].vld_q;
        endcase
    end
endmodule

// File: rtl/hrow_act_gate.sv
// Half-row activation gate for one bank.
// Combines the open-state policy, the spacing timer and the rolling window
// into a combinational grant. An activation issues when request and grant are
// both high. A request in a precharge cycle is never granted.
module hrow_act_gate
    import hrow_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int SUB_W = 2,
    parameter int TRRD  = 4,
    parameter int TFAW  = 20,
    parameter int NACT  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             act_req_i,
    input  logic [ROW_W-1:0] act_row_i,
    input  logic [SUB_W-1:0] act_sub_i,
    input  logic             act_half_i,
    input  logic             pre_i,
    output logic             act_grant_o
);
    logic policy_ok, rrd_ok, faw_ok, issue;

    hrow_open_track #(.ROW_W(ROW_W), .SUB_W(SUB_W)) u_open (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (act_pol_e'(mode_i)),
        .issue_i     (issue),
        .pre_i       (pre_i),
        .row_i       (act_row_i),
        .sub_i       (act_sub_i),
        .half_i      (act_half_i),
        .policy_ok_o (policy_ok)
    );

    hrow_rrd_timer #(.ROW_W(ROW_W), .SUB_W(SUB_W), .TRRD(TRRD)) u_rrd (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (issue),
        .row_i   (act_row_i),
        .sub_i   (act_sub_i),
        .ok_o    (rrd_ok)
    );

    hrow_faw_window #(.NACT(NACT), .TFAW(TFAW)) u_faw (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (issue),
        .ok_o    (faw_ok)
    );

    // Grant only when every rule admits the request.
    always_comb begin
        act_grant_o = act_req_i && !pre_i && policy_ok && rrd_ok && faw_ok;
        issue       = act_grant_o;
    end
endmodule

// File: rtl/hrow_act_gate_chk.sv
// Property checker for the half-row activation gate.
// Keeps its own view of the issue history and open count from the ports.
// Assumes TFAW >= 3.
module hrow_act_gate_chk #(
    parameter int ROW_W = 4,
    parameter int SUB_W = 2,
    parameter int TRRD  = 4,
    parameter int TFAW  = 20,
    parameter int NACT  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             act_req_i,
    input logic [ROW_W-1:0] act_row_i,
    input logic [SUB_W-1:0] act_sub_i,
    input logic             pre_i,
    input logic             act_grant_o
);
    localparam int CW = $clog2(TRRD + 1);

    logic             fired;
    logic [CW-1:0]    gap_q;
    logic             seen_q;
    logic [ROW_W-1:0] lrow_q;
    logic [SUB_W-1:0] lsub_q;
    logic [TFAW-2:0]  hist_q;
    logic [1:0]       opn_q;

    assign fired = act_req_i && act_grant_o;

    // Track the last issue, the window history and the open count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            lrow_q <= '0;
            lsub_q <= '0;
            hist_q <= '0;
            opn_q  <= '0;
        end else begin
            hist_q <= {hist_q[TFAW-3:0], fired};
            if (fired) begin
                gap_q  <= CW'(1);
                seen_q <= 1'b1;
                lrow_q <= act_row_i;
                lsub_q <= act_sub_i;
            end else if (gap_q < CW'(TRRD)) begin
                gap_q <= gap_q + CW'(1);
            end
            if (pre_i)      opn_q <= '0;
            else if (fired) opn_q <= opn_q + 2'd1;
        end
    end

    // R7
    rrd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && seen_q && ((act_row_i != lrow_q) || (act_sub_i != lsub_q)))
        |-> (gap_q >= CW'(TRRD)));

    // R8
    faw_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fired |-> ($countones(hist_q) < NACT));

    // R3
    single_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && (mode_i != 2'd1) && (mode_i != 2'd2)) |-> (opn_q == 2'd0));

    // R6
    dual_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fired |-> (opn_q < 2'd2));

    // R2
    pre_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> !act_grant_o);
endmodule

bind hrow_act_gate hrow_act_gate_chk #(
    .ROW_W(ROW_W), .SUB_W(SUB_W), .TRRD(TRRD), .TFAW(TFAW), .NACT(NACT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .act_req_i   (act_req_i),
    .act_row_i   (act_row_i),
    .act_sub_i   (act_sub_i),
    .pre_i       (pre_i),
    .act_grant_o (act_grant_o)
);

// File: tb/test_hrow_act_gate.sv
`timescale 1ns/1ps
// Bench: sweeps two-request scenarios over modes, halves, targets and gaps,
// then runs issue/precharge bursts and a pseudo-random run. Every cycle's
// grant is compared with an arithmetic model of the requirements.
module test_hrow_act_gate;
    localparam int ROW_W = 3;
    localparam int SUB_W = 2;
    localparam int TRRD  = 3;
    localparam int TFAW  = 20;
    localparam int NACT  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_i = '0;
    logic             act_req_i = 1'b0;
    logic [ROW_W-1:0] act_row_i = '0;
    logic [SUB_W-1:0] act_sub_i = '0;
    logic             act_half_i = 1'b0;
    logic             pre_i = 1'b0;
    logic             act_grant_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    hrow_act_gate #(.ROW_W(ROW_W), .SUB_W(SUB_W), .TRRD(TRRD), .TFAW(TFAW),
                    .NACT(NACT)) i_hrow_act_gate (.*);

    // Model state
    int               cyc = 0;
    logic             m_open [2];
    logic [ROW_W-1:0] m_row [2];
    logic [SUB_W-1:0] m_sub [2];
    logic             m_have = 1'b0;
    logic [ROW_W-1:0] m_lrow = '0;
    logic [SUB_W-1:0] m_lsub = '0;
    int               m_lcyc = 0;
    int               m_q [NACT];
    int               m_wr = 0;
    int               m_n = 0;

    function automatic logic model(input logic [1:0] m, input logic r,
        input logic [ROW_W-1:0] rw, input logic [SUB_W-1:0] sb,
        input logic hf, input logic p);
        logic pol, own, oth;
        if (!r || p) return 1'b0;
        own = m_open[hf];
        oth = m_open[!hf];
        if (m == 2'd1)
            pol = !own && (!oth || (m_row[!hf] == rw && m_sub[!hf] == sb));
        else if (m == 2'd2)
            pol = !own && (!oth || m_sub[!hf] != sb || m_row[!hf] == rw);
        else
            pol = !m_open[0] && !m_open[1];
        if (!pol) return 1'b0;
        if (m_have && (rw != m_lrow || sb != m_lsub) && (cyc - m_lcyc) < TRRD)
            return 1'b0;
        if (m_n >= NACT && (cyc - m_q[m_wr]) < TFAW) return 1'b0;
        return 1'b1;
    endfunction

    // One cycle: drive at negedge, check grant, advance the model.
    task automatic step(input logic [1:0] m, input logic r,
        input logic [ROW_W-1:0] rw, input logic [SUB_W-1:0] sb,
        input logic hf, input logic p, input string tag);
        logic exp;
        @(negedge clk);
        mode_i = m; act_req_i = r; act_row_i = rw; act_sub_i = sb;
        act_half_i = hf; pre_i = p;
        #1;
        exp = model(m, r, rw, sb, hf, p);
        total++;
        if (act_grant_o !== exp) begin
            bad++;
            $display("FAIL %s cyc=%0d mode=%0d req=%0b row=%0d sub=%0d half=%0b pre=%0b grant=%0b expected=%0b",
                     tag, cyc, m, r, rw, sb, hf, p, act_grant_o, exp);
        end
        if (p) begin
            m_open[0] = 1'b0; m_open[1] = 1'b0;
        end else if (exp) begin
            m_open[hf] = 1'b1; m_row[hf] = rw; m_sub[hf] = sb;
            m_have = 1'b1; m_lrow = rw; m_lsub = sb; m_lcyc = cyc;
            m_q[m_wr] = cyc; m_wr = (m_wr + 1) % NACT;
            if (m_n < NACT) m_n++;
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(2'd0, 1'b0, '0, '0, 1'b0, 1'b0, "R1");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        string t2;
        m_open[0] = 1'b0; m_open[1] = 1'b0;
        m_row[0] = '0; m_row[1] = '0; m_sub[0] = '0; m_sub[1] = '0;
        for (int i = 0; i < NACT; i++) m_q[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, idle grant low, then a fresh request is granted.
        idle(2);
        step(2'd0, 1'b1, 3'd1, 2'd1, 1'b0, 1'b0, "R1");
        step(2'd0, 1'b0, '0, '0, 1'b0, 1'b1, "R2");

        // R3 R4 R5 R6 R7: two-request sweep.
        for (int m = 0; m < 4; m++)
            for (int h1 = 0; h1 < 2; h1++)
                for (int h2 = 0; h2 < 2; h2++)
                    for (int rd = 0; rd < 2; rd++)
                        for (int sd = 0; sd < 2; sd++)
                            for (int g = 0; g <= TRRD + 1; g++) begin
                                step(2'(m), 1'b0, '0, '0, 1'b0, 1'b1, "R2");
                                idle(TFAW);
                                step(2'(m), 1'b1, 3'd1, 2'd1, 1'(h1), 1'b0, "R1");
                                idle(g);
                                t2 = (m == 1) ? "R4 R7" : (m == 2) ? "R5 R7" : "R3 R7";
                                if (h1 == h2) t2 = "R6";
                                step(2'(m), 1'b1, rd ? 3'd2 : 3'd1, sd ? 2'd2 : 2'd1,
                                     1'(h2), 1'b0, t2);
                            end

        // R6: both halves open in dual mode, third request rejected.
        step(2'd2, 1'b0, '0, '0, 1'b0, 1'b1, "R2");
        idle(TFAW);
        step(2'd2, 1'b1, 3'd3, 2'd0, 1'b0, 1'b0, "R5");
        idle(TRRD);
        step(2'd2, 1'b1, 3'd4, 2'd1, 1'b1, 1'b0, "R5");
        idle(TRRD);
        step(2'd2, 1'b1, 3'd5, 2'd2, 1'b0, 1'b0, "R6");
        step(2'd2, 1'b1, 3'd4, 2'd1, 1'b1, 1'b0, "R6");

        // R2: request with precharge blocked, next cycle granted again.
        step(2'd0, 1'b1, 3'd4, 2'd1, 1'b1, 1'b1, "R2");
        step(2'd0, 1'b1, 3'd4, 2'd1, 1'b1, 1'b0, "R2");

        // R9: precharge keeps spacing history; a new row right after waits.
        step(2'd2, 1'b0, '0, '0, 1'b0, 1'b1, "R2");
        step(2'd2, 1'b1, 3'd6, 2'd3, 1'b0, 1'b0, "R9");
        step(2'd2, 1'b1, 3'd6, 2'd3, 1'b0, 1'b0, "R9");
        idle(TRRD);
        step(2'd2, 1'b1, 3'd6, 2'd3, 1'b0, 1'b0, "R9");

        // R8: issue/precharge bursts on one row until the window blocks.
        step(2'd0, 1'b0, '0, '0, 1'b0, 1'b1, "R2");
        idle(TFAW);
        for (int i = 0; i < 3 * TFAW; i++) begin
            step(2'd0, 1'b1, 3'd2, 2'd0, 1'b0, 1'b0, "R8");
            step(2'd0, 1'b0, '0, '0, 1'b0, 1'b1, "R8");
        end

        // R9: pseudo-random traffic against the model.
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(2'((i / 97) % 4), lfsr[0], {1'b0, lfsr[2:1]}, {1'b0, lfsr[3]},
                 lfsr[4], lfsr[7:5] == 3'd0, "R9");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule